// File: doc/BRIEF.md
# Reserving Set-Associative Tag Controller

This block keeps the tags and per-line state of a set-associative cache. It supports write-back and write-through operation. In write-back mode a read miss claims a way at once, holding it in a pending state until the line's data comes back. A request to a claimed way is then reported as a hit on an outstanding miss and is not treated as a fresh miss. When every way of a set is pending, the block refuses the request, and the requester must try again later. The data array, miss tracking and memory traffic live outside the block.

Two single-cycle strobed ports drive the block. The lookup port takes an address and a write flag. One cycle later it returns a status code and, when a dirty line was displaced, that line's stored address. The fill port takes the address of returning data. In write-back mode it completes a pending way. In write-through mode it installs the line directly, and it can displace a dirty line, whose address it then reports. Recency and fill-order stamps come from an internal free-running cycle counter. The victim of a replacement is chosen either by least-recent use or by first-in first-out, which a configuration input selects.

Top module: `rsv_tag_ctrl`

## Requirements
- R1: The set index is address bits [OFFSET_W +: INDEX_W] (the bits just above the line offset) and the tag is every bit above the index; addresses that differ only in offset bits map to the same line, and equal tags in different sets are distinct lines.
- R2: A lookup whose tag matches a valid, non-pending way returns code 0 (write-back) or code 1 (write-through), refreshes that way's recency stamp, and marks the way dirty when the lookup is a write.
- R3: A lookup whose tag matches a pending way returns code 2; a write also marks that way dirty, and the dirty state survives the fill.
- R4: In write-through mode, or for a write lookup that matches no way, the result is code 3 and no way is claimed.
- R5: A write-back read miss in a set whose ways are all pending returns code 5 and alters no state.
- R6: A write-back read miss claims the lowest-numbered way that is neither valid nor pending, marks it pending with the new tag, and returns code 3.
- R7: When no free way exists, the victim is the valid non-pending way with the oldest recency stamp (cfg_fifo=0) or oldest fill stamp (cfg_fifo=1), lowest way on a tie; a dirty victim gives code 4 with its stored address on lk_wb_addr, a clean one gives code 3; the victim becomes pending, invalid and clean with the new tag.
- R8: A write-back fill whose tag matches a pending way makes that way valid, clears pending, keeps its dirty bit, and stores the fill address and both stamps.
- R9: A fill whose tag matches a valid way is discarded: no state change and no write-back report.
- R10: A write-through fill uses the lowest invalid way, else the oldest valid way by the selected policy; fl_wb_valid with fl_wb_addr reports the displaced line only when it was valid and dirty; the new line is installed valid and clean.
- R11: A write-back fill that matches no pending or valid way sets fill_err, which stays set until reset, and alters no line.
- R12: lk_done (with lk_code) and fl_done (with fl_wb_valid) pulse exactly one cycle after their strobe; when both strobes are high together the fill is performed and the lookup is dropped.
- R13: After reset no way is valid, pending or dirty, and lk_done, fl_done, fl_wb_valid and fill_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wthru | input | 1 | 1 selects write-through mode, 0 write-back |
| cfg_fifo | input | 1 | 1 selects fill-order replacement, 0 least-recent use |
| lk_valid | input | 1 | Lookup strobe |
| lk_write | input | 1 | Lookup is a write |
| lk_addr | input | ADDR_W | Lookup byte address |
| fl_valid | input | 1 | Fill strobe |
| fl_addr | input | ADDR_W | Fill byte address |
| lk_done | output | 1 | Lookup result valid |
| lk_code | output | 3 | Lookup status code |
| lk_wb_addr | output | ADDR_W | Address of the dirty line displaced by a lookup (code 4) |
| fl_done | output | 1 | Fill processed |
| fl_wb_valid | output | 1 | A write-through fill displaced a dirty line |
| fl_wb_addr | output | ADDR_W | Address of that displaced line |
| fill_err | output | 1 | Sticky flag: write-back fill without a pending way |

## Verification
One set is filled and then overloaded with read misses while the hit order is varied. This shows whether the victim follows the recency stamp or the fill stamp, and whether a write on a pending or hit line later appears as a write-back. Runs that leave every way pending, that repeat a lookup after a write miss, and that repeat a fill or send a fill with no matching way separate refusal, non-allocation and discard from real state changes. The same address patterns run in both write policies and both replacement orders. A cycle with both strobes high checks the priority between the ports.

// File: rtl/rsv_tag_pkg.sv
package rsv_tag_pkg;

    typedef enum logic [2:0] {
        LK_HIT        = 3'd0,
        LK_HIT_WT     = 3'd1,
        LK_PEND_HIT   = 3'd2,
        LK_MISS_CLEAN = 3'd3,
        LK_MISS_WB    = 3'd4,
        LK_RSV_FAIL   = 3'd5
    } lk_code_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic pend;
    } line_flags_t;

    localparam line_flags_t FLAGS_EMPTY = '{valid: 1'b0, dirty: 1'b0, pend: 1'b0};

endpackage

// File: rtl/rsv_way_match.sv
module rsv_way_match
    import rsv_tag_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 26
) (
    input  logic [TAG_W-1:0] key,
    input  logic [TAG_W-1:0] tags  [NUM_WAYS],
    input  line_flags_t      flags [NUM_WAYS],
    output logic [NUM_WAYS-1:0] valid_hit,
    output logic [NUM_WAYS-1:0] pend_hit,
    output logic [NUM_WAYS-1:0] free_vec,
    output logic [NUM_WAYS-1:0] open_vec,
    output logic [NUM_WAYS-1:0] live_vec
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic same;
        assign same         = (tags[w] == key);
        assign valid_hit[w] = same && flags[w].valid && !flags[w].pend;
        assign pend_hit[w]  = same && flags[w].pend;
        assign free_vec[w]  = !flags[w].valid && !flags[w].pend;
        assign open_vec[w]  = !flags[w].pend;
        assign live_vec[w]  = flags[w].valid && !flags[w].pend;
    end
endmodule

// File: rtl/rsv_first_set.sv
module rsv_first_set #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rsv_oldest_pick.sv
module rsv_oldest_pick #(
    parameter int N       = 4,
    parameter int STAMP_W = 16,
    parameter int IDX_W   = 2
) (
    input  logic [N-1:0]       cand,
    input  logic [STAMP_W-1:0] stamps [N],
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    logic [STAMP_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || stamps[i] < best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = stamps[i];
            end
        end
    end
endmodule

// File: rtl/rsv_tag_ctrl.sv
module rsv_tag_ctrl
    import rsv_tag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int NUM_SETS   = 4,
    parameter int NUM_WAYS   = 4,
    parameter int STAMP_W    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wthru,
    input  logic              cfg_fifo,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fl_valid,
    input  logic [ADDR_W-1:0] fl_addr,
    output logic              lk_done,
    output logic [2:0]        lk_code,
    output logic [ADDR_W-1:0] lk_wb_addr,
    output logic              fl_done,
    output logic              fl_wb_valid,
    output logic [ADDR_W-1:0] fl_wb_addr,
    output logic              fill_err
);
    localparam int OFFSET_W = $clog2(LINE_BYTES);
    localparam int INDEX_W  = $clog2(NUM_SETS);
    localparam int TAG_W    = ADDR_W - OFFSET_W - INDEX_W;
    localparam int WAY_W    = $clog2(NUM_WAYS);

    // line state
    line_flags_t         flags_q [NUM_SETS][NUM_WAYS];
    logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
    logic [ADDR_W-1:0]   addr_q  [NUM_SETS][NUM_WAYS];
    logic [STAMP_W-1:0]  use_q   [NUM_SETS][NUM_WAYS];
    logic [STAMP_W-1:0]  fill_q  [NUM_SETS][NUM_WAYS];
    logic [STAMP_W-1:0]  now_q;

    // registered results
    lk_code_e            lk_code_q;
    logic                lk_done_q, fl_done_q, fl_wb_q, err_q;
    logic [ADDR_W-1:0]   lk_wb_q, fl_wb_addr_q;

    // address split
    logic [INDEX_W-1:0]  lk_set, fl_set;
    logic [TAG_W-1:0]    lk_tag, fl_tag;
    logic                lk_off_unused;

    assign lk_set        = lk_addr[OFFSET_W +: INDEX_W];
    assign lk_tag        = lk_addr[ADDR_W-1 -: TAG_W];
    assign fl_set        = fl_addr[OFFSET_W +: INDEX_W];
    assign fl_tag        = fl_addr[ADDR_W-1 -: TAG_W];
    assign lk_off_unused = ^lk_addr[OFFSET_W-1:0];

    // rows of the addressed sets
    logic [TAG_W-1:0]   lk_tags [NUM_WAYS], fl_tags [NUM_WAYS];
    line_flags_t        lk_flg  [NUM_WAYS], fl_flg  [NUM_WAYS];
    logic [STAMP_W-1:0] lk_age  [NUM_WAYS], fl_age  [NUM_WAYS];

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            lk_tags[w] = tag_q[lk_set][w];
            lk_flg[w]  = flags_q[lk_set][w];
            lk_age[w]  = cfg_fifo ? fill_q[lk_set][w] : use_q[lk_set][w];
            fl_tags[w] = tag_q[fl_set][w];
            fl_flg[w]  = flags_q[fl_set][w];
            fl_age[w]  = cfg_fifo ? fill_q[fl_set][w] : use_q[fl_set][w];
        end
    end

    logic [NUM_WAYS-1:0] lk_vhit, lk_phit, lk_free, lk_open, lk_live;
    logic [NUM_WAYS-1:0] fl_vhit, fl_phit, fl_free, fl_open_unused, fl_live;

    rsv_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_lk_match (
        .key(lk_tag), .tags(lk_tags), .flags(lk_flg),
        .valid_hit(lk_vhit), .pend_hit(lk_phit), .free_vec(lk_free),
        .open_vec(lk_open), .live_vec(lk_live)
    );

    rsv_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_fl_match (
        .key(fl_tag), .tags(fl_tags), .flags(fl_flg),
        .valid_hit(fl_vhit), .pend_hit(fl_phit), .free_vec(fl_free),
        .open_vec(fl_open_unused), .live_vec(fl_live)
    );

    logic             lk_free_found, fl_free_found, lk_vic_found, fl_vic_found;
    logic [WAY_W-1:0] lk_free_idx, fl_free_idx, lk_vic_idx, fl_vic_idx;

    rsv_first_set #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_lk_free (
        .vec(lk_free), .found(lk_free_found), .idx(lk_free_idx)
    );
    rsv_first_set #(.N(NUM_WAYS), .IDX_W(WAY_W)) u_fl_free (
        .vec(fl_free), .found(fl_free_found), .idx(fl_free_idx)
    );
    rsv_oldest_pick #(.N(NUM_WAYS), .STAMP_W(STAMP_W), .IDX_W(WAY_W)) u_lk_vic (
        .cand(lk_live), .stamps(lk_age), .found(lk_vic_found), .idx(lk_vic_idx)
    );
    rsv_oldest_pick #(.N(NUM_WAYS), .STAMP_W(STAMP_W), .IDX_W(WAY_W)) u_fl_vic (
        .cand(fl_live), .stamps(fl_age), .found(fl_vic_found), .idx(fl_vic_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    flags_q[s][w] <= FLAGS_EMPTY;
                    tag_q[s][w]   <= '0;
                    addr_q[s][w]  <= '0;
                    use_q[s][w]   <= '0;
                    fill_q[s][w]  <= '0;
                end
            end
            now_q        <= '0;
            lk_done_q    <= 1'b0;
            lk_code_q    <= LK_HIT;
            lk_wb_q      <= '0;
            fl_done_q    <= 1'b0;
            fl_wb_q      <= 1'b0;
            fl_wb_addr_q <= '0;
            err_q        <= 1'b0;
        end else begin
            now_q     <= now_q + 1'b1;
            lk_done_q <= 1'b0;
            fl_done_q <= 1'b0;
            fl_wb_q   <= 1'b0;
            if (fl_valid) begin
                fl_done_q <= 1'b1;
                if (|fl_vhit) begin
                    // duplicate fill: nothing changes
                end else if (!cfg_wthru) begin
                    if (|fl_phit) begin
                        for (int w = 0; w < NUM_WAYS; w++) begin
                            if (fl_phit[w]) begin
                                flags_q[fl_set][w].pend  <= 1'b0;
                                flags_q[fl_set][w].valid <= 1'b1;
                                addr_q[fl_set][w]        <= fl_addr;
                                use_q[fl_set][w]         <= now_q;
                                fill_q[fl_set][w]        <= now_q;
                            end
                        end
                    end else begin
                        err_q <= 1'b1;
                    end
                end else if (fl_free_found || fl_vic_found) begin
                    if (fl_free_found) begin
                        flags_q[fl_set][fl_free_idx] <= '{valid: 1'b1, dirty: 1'b0, pend: 1'b0};
                        tag_q[fl_set][fl_free_idx]   <= fl_tag;
                        addr_q[fl_set][fl_free_idx]  <= fl_addr;
                        use_q[fl_set][fl_free_idx]   <= now_q;
                        fill_q[fl_set][fl_free_idx]  <= now_q;
                    end else begin
                        if (fl_flg[fl_vic_idx].dirty) begin
                            fl_wb_q      <= 1'b1;
                            fl_wb_addr_q <= addr_q[fl_set][fl_vic_idx];
                        end
                        flags_q[fl_set][fl_vic_idx] <= '{valid: 1'b1, dirty: 1'b0, pend: 1'b0};
                        tag_q[fl_set][fl_vic_idx]   <= fl_tag;
                        addr_q[fl_set][fl_vic_idx]  <= fl_addr;
                        use_q[fl_set][fl_vic_idx]   <= now_q;
                        fill_q[fl_set][fl_vic_idx]  <= now_q;
                    end
                end
            end else if (lk_valid) begin
                lk_done_q <= 1'b1;
                if (|lk_vhit) begin
                    lk_code_q <= cfg_wthru ? LK_HIT_WT : LK_HIT;
                    for (int w = 0; w < NUM_WAYS; w++) begin
                        if (lk_vhit[w]) begin
                            use_q[lk_set][w] <= now_q;
                            if (lk_write) flags_q[lk_set][w].dirty <= 1'b1;
                        end
                    end
                end else if (|lk_phit) begin
                    lk_code_q <= LK_PEND_HIT;
                    for (int w = 0; w < NUM_WAYS; w++) begin
                        if (lk_phit[w] && lk_write) flags_q[lk_set][w].dirty <= 1'b1;
                    end
                end else if (cfg_wthru || lk_write) begin
                    lk_code_q <= LK_MISS_CLEAN;
                end else if (!(|lk_open)) begin
                    lk_code_q <= LK_RSV_FAIL;
                end else if (lk_free_found) begin
                    lk_code_q                    <= LK_MISS_CLEAN;
                    flags_q[lk_set][lk_free_idx] <= '{valid: 1'b0, dirty: 1'b0, pend: 1'b1};
                    tag_q[lk_set][lk_free_idx]   <= lk_tag;
                end else if (lk_vic_found) begin
                    if (lk_flg[lk_vic_idx].dirty) begin
                        lk_code_q <= LK_MISS_WB;
                        lk_wb_q   <= addr_q[lk_set][lk_vic_idx];
                    end else begin
                        lk_code_q <= LK_MISS_CLEAN;
                    end
                    flags_q[lk_set][lk_vic_idx] <= '{valid: 1'b0, dirty: 1'b0, pend: 1'b1};
                    tag_q[lk_set][lk_vic_idx]   <= lk_tag;
                end
            end
        end
    end

    assign lk_done     = lk_done_q;
    assign lk_code     = lk_code_q;
    assign lk_wb_addr  = lk_wb_q;
    assign fl_done     = fl_done_q;
    assign fl_wb_valid = fl_wb_q;
    assign fl_wb_addr  = fl_wb_addr_q;
    assign fill_err    = err_q;

endmodule

// File: rtl/rsv_tag_ctrl_chk.sv
module rsv_tag_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wthru,
    input logic              lk_valid,
    input logic              fl_valid,
    input logic              lk_done,
    input logic [2:0]        lk_code,
    input logic              fl_done,
    input logic              fl_wb_valid,
    input logic              fill_err
);
    // R12: lookup answered one cycle after its strobe when no fill competes
    p_lk_done_r12: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !fl_valid) |=> lk_done);

    // R12: fill answered one cycle later and wins over a same-cycle lookup
    p_fl_wins_r12: assert property (@(posedge clk) disable iff (rst)
        fl_valid |=> (fl_done && !lk_done));

    // R12: no result pulse without a strobe
    p_no_spurious_r12: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !lk_done);

    // R4: write-through mode yields only write-through hit, pending hit or clean miss
    p_wt_codes_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_done && cfg_wthru) |-> (lk_code == 3'd1 || lk_code == 3'd2 || lk_code == 3'd3));

    // R2: codes stay in the defined range
    p_code_range_r2: assert property (@(posedge clk) disable iff (rst)
        lk_done |-> (lk_code <= 3'd5));

    // R10: write-back report only in write-through mode and with a fill result
    p_fl_wb_r10: assert property (@(posedge clk) disable iff (rst)
        fl_wb_valid |-> (fl_done && cfg_wthru));

    // R11: error flag is sticky and only rises after a fill
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        fill_err |=> fill_err);
    p_err_cause_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(fill_err) |-> fl_done);
endmodule

bind rsv_tag_ctrl rsv_tag_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cfg_wthru(cfg_wthru), .lk_valid(lk_valid),
    .fl_valid(fl_valid), .lk_done(lk_done), .lk_code(lk_code),
    .fl_done(fl_done), .fl_wb_valid(fl_wb_valid), .fill_err(fill_err)
);

// File: tb/rsv_tag_ctrl_bench.sv
module rsv_tag_ctrl_bench;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wthru = 1'b0, cfg_fifo = 1'b0;
    logic lk_valid = 1'b0, lk_write = 1'b0, fl_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0, fl_addr = '0;
    logic lk_done, fl_done, fl_wb_valid, fill_err;
    logic [2:0] lk_code;
    logic [AW-1:0] lk_wb_addr, fl_wb_addr;

    always #2 clk = ~clk;   // 250 MHz

    rsv_tag_ctrl u_rsv_tag_ctrl (
        .clk(clk), .rst(rst), .cfg_wthru(cfg_wthru), .cfg_fifo(cfg_fifo),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_addr(lk_addr),
        .fl_valid(fl_valid), .fl_addr(fl_addr),
        .lk_done(lk_done), .lk_code(lk_code), .lk_wb_addr(lk_wb_addr),
        .fl_done(fl_done), .fl_wb_valid(fl_wb_valid), .fl_wb_addr(fl_wb_addr),
        .fill_err(fill_err)
    );

    int n_cmp = 0, n_bad = 0;

    // behavioural reference: 4 sets x 4 ways, 16-byte lines
    bit          mv [4][4], md [4][4], mp [4][4];
    int          mtag [4][4];
    logic [31:0] maddr [4][4];
    int          mlu [4][4], mft [4][4];
    int          now;
    bit          m_wt, m_fifo, m_err;
    bit          e_lk_done, e_fl_done, e_fl_wb;
    int          e_code;
    logic [31:0] e_lk_wb, e_fl_wb_addr;

    function automatic logic [31:0] mk(int t, int s, int o);
        return {t[25:0], s[1:0], o[3:0]};
    endfunction

    function automatic int age(int s, int w);
        return m_fifo ? mft[s][w] : mlu[s][w];
    endfunction

    task automatic model_clear();
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                mv[s][w] = 0; md[s][w] = 0; mp[s][w] = 0;
                mtag[s][w] = -1; maddr[s][w] = '0; mlu[s][w] = 0; mft[s][w] = 0;
            end
        now = 0; m_err = 0;
    endtask

    task automatic model_lookup(logic [31:0] a, bit wr);
        int s, t, hw, pw, fw, vw;
        bit any_open;
        s = int'(a[5:4]); t = int'(a[31:6]);
        hw = -1; pw = -1; fw = -1; vw = -1; any_open = 0;
        for (int w = 0; w < 4; w++) begin
            if (mv[s][w] && !mp[s][w] && mtag[s][w] == t) hw = w;
            if (mp[s][w] && mtag[s][w] == t) pw = w;
            if (!mp[s][w]) any_open = 1;
            if (!mv[s][w] && !mp[s][w] && fw < 0) fw = w;
            if (mv[s][w] && !mp[s][w] && (vw < 0 || age(s, w) < age(s, vw))) vw = w;
        end
        e_lk_done = 1;
        if (hw >= 0) begin
            e_code = m_wt ? 1 : 0; mlu[s][hw] = now;
            if (wr) md[s][hw] = 1;
        end else if (pw >= 0) begin
            e_code = 2;
            if (wr) md[s][pw] = 1;
        end else if (m_wt || wr) e_code = 3;
        else if (!any_open) e_code = 5;
        else if (fw >= 0) begin
            e_code = 3; mp[s][fw] = 1; mtag[s][fw] = t;
        end else begin
            if (md[s][vw]) begin e_code = 4; e_lk_wb = maddr[s][vw]; end
            else e_code = 3;
            mp[s][vw] = 1; mv[s][vw] = 0; md[s][vw] = 0; mtag[s][vw] = t;
        end
    endtask

    task automatic model_fill(logic [31:0] a);
        int s, t, hw, pw, fw, vw, tw;
        s = int'(a[5:4]); t = int'(a[31:6]);
        hw = -1; pw = -1; fw = -1; vw = -1;
        for (int w = 0; w < 4; w++) begin
            if (mv[s][w] && !mp[s][w] && mtag[s][w] == t) hw = w;
            if (mp[s][w] && mtag[s][w] == t) pw = w;
            if (!mv[s][w] && !mp[s][w] && fw < 0) fw = w;
            if (mv[s][w] && !mp[s][w] && (vw < 0 || age(s, w) < age(s, vw))) vw = w;
        end
        e_fl_done = 1;
        if (hw >= 0) begin
        end else if (!m_wt) begin
            if (pw >= 0) begin
                mp[s][pw] = 0; mv[s][pw] = 1; maddr[s][pw] = a;
                mlu[s][pw] = now; mft[s][pw] = now;
            end else m_err = 1;
        end else begin
            tw = (fw >= 0) ? fw : vw;
            if (fw < 0 && md[s][tw]) begin e_fl_wb = 1; e_fl_wb_addr = maddr[s][tw]; end
            mv[s][tw] = 1; md[s][tw] = 0; mp[s][tw] = 0; mtag[s][tw] = t;
            maddr[s][tw] = a; mlu[s][tw] = now; mft[s][tw] = now;
        end
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        chk(req, "lk_done", 32'(lk_done), 32'(e_lk_done));
        if (e_lk_done) begin
            chk(req, "lk_code", 32'(lk_code), 32'(e_code));
            if (e_code == 4) chk(req, "lk_wb_addr", lk_wb_addr, e_lk_wb);
        end
        chk(req, "fl_done", 32'(fl_done), 32'(e_fl_done));
        if (e_fl_done) begin
            chk(req, "fl_wb_valid", 32'(fl_wb_valid), 32'(e_fl_wb));
            if (e_fl_wb) chk(req, "fl_wb_addr", fl_wb_addr, e_fl_wb_addr);
        end
        chk(req, "fill_err", 32'(fill_err), 32'(m_err));
    endtask

    // one clock: drive, advance reference, sample after the edge
    task automatic cyc(string req, bit lv, bit lw, logic [31:0] la, bit fv, logic [31:0] fa);
        @(negedge clk);
        lk_valid = lv; lk_write = lw; lk_addr = la; fl_valid = fv; fl_addr = fa;
        e_lk_done = 0; e_fl_done = 0; e_fl_wb = 0;
        now++;
        if (fv) model_fill(fa);
        else if (lv) model_lookup(la, lw);
        @(posedge clk); #1;
        compare_all(req);
    endtask

    task automatic rd(string req, logic [31:0] a);  cyc(req, 1, 0, a, 0, '0); endtask
    task automatic wr(string req, logic [31:0] a);  cyc(req, 1, 1, a, 0, '0); endtask
    task automatic fl(string req, logic [31:0] a);  cyc(req, 0, 0, '0, 1, a); endtask
    task automatic idle(string req);                cyc(req, 0, 0, '0, 0, '0); endtask

    task automatic do_reset(bit wt, bit fifo);
        @(negedge clk);
        rst = 1; lk_valid = 0; fl_valid = 0; cfg_wthru = wt; cfg_fifo = fifo;
        m_wt = wt; m_fifo = fifo; model_clear();
        e_lk_done = 0; e_fl_done = 0; e_fl_wb = 0;
        repeat (2) @(posedge clk);
        #1;
        // R13: outputs quiet under reset
        chk("R13", "lk_done", 32'(lk_done), 0);
        chk("R13", "fl_done", 32'(fl_done), 0);
        chk("R13", "fl_wb_valid", 32'(fl_wb_valid), 0);
        chk("R13", "fill_err", 32'(fill_err), 0);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // ---- write-back, least-recent use ----
        do_reset(0, 0);
        idle("R13");
        rd("R6", mk(1, 0, 0));          // claim way 0
        rd("R3", mk(1, 0, 4));          // pending hit
        wr("R3", mk(1, 0, 8));          // pending hit marks dirty
        fl("R8", mk(1, 0, 0));          // completes, dirty kept
        rd("R1", mk(1, 0, 12));         // offset-only difference hits
        fl("R9", mk(1, 0, 0));          // duplicate fill discarded
        for (int t = 2; t <= 4; t++) begin
            rd("R6", mk(t, 0, 0));
            fl("R8", mk(t, 0, 0));
        end
        rd("R2", mk(1, 0, 0));          // refresh tag 1 recency
        rd("R7", mk(5, 0, 0));          // evicts tag 2 (clean)
        rd("R7", mk(6, 0, 0));          // evicts tag 3
        wr("R2", mk(1, 0, 0));          // write hit
        rd("R7", mk(7, 0, 0));          // evicts tag 4
        rd("R7", mk(8, 0, 0));          // evicts dirty tag 1: write-back
        rd("R5", mk(9, 0, 0));          // every way pending
        rd("R5", mk(9, 0, 0));          // still refused, no state change
        fl("R8", mk(5, 0, 0));
        rd("R7", mk(9, 0, 0));          // only tag 5 is evictable
        rd("R1", mk(1, 1, 0));          // same tag, other set: miss
        wr("R4", mk(10, 1, 0));         // write miss, no claim
        rd("R4", mk(10, 1, 0));         // still a fresh miss
        cyc("R12", 1, 0, mk(11, 2, 0), 1, mk(10, 1, 0)); // fill wins, lookup dropped
        rd("R12", mk(11, 2, 0));        // dropped lookup left no claim
        fl("R11", mk(20, 3, 0));        // fill with no pending way
        idle("R11");
        rd("R11", mk(20, 3, 0));        // line not installed
        idle("R12");

        // ---- write-back, fill order ----
        do_reset(0, 1);
        for (int t = 1; t <= 4; t++) begin
            rd("R6", mk(t, 2, 0));
            fl("R8", mk(t, 2, 0));
        end
        wr("R2", mk(1, 2, 0));          // recent use does not protect under fill order
        rd("R7", mk(5, 2, 0));          // evicts tag 1 with write-back
        rd("R7", mk(6, 2, 0));          // evicts tag 2, clean

        // ---- write-through, least-recent use ----
        do_reset(1, 0);
        rd("R4", mk(1, 0, 0));          // miss, no claim
        fl("R10", mk(1, 0, 0));
        wr("R2", mk(1, 0, 4));          // write-through hit, dirty
        for (int t = 2; t <= 4; t++) fl("R10", mk(t, 0, 0));
        fl("R9", mk(2, 0, 0));          // duplicate discarded
        rd("R2", mk(2, 0, 0));
        fl("R10", mk(5, 0, 0));         // evicts dirty tag 1
        fl("R10", mk(6, 0, 0));         // evicts tag 3, clean
        rd("R10", mk(3, 0, 0));         // gone
        rd("R10", mk(6, 0, 0));         // installed

        // ---- write-through, fill order ----
        do_reset(1, 1);
        for (int t = 1; t <= 4; t++) fl("R10", mk(t, 3, 0));
        wr("R2", mk(1, 3, 0));
        rd("R2", mk(2, 3, 0));
        fl("R10", mk(5, 3, 0));         // oldest fill is tag 1, dirty
        fl("R10", mk(6, 3, 0));         // then tag 2
        idle("R12");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule